// File: doc/BRIEF.md
# String Port Transfer Sequencer

This block moves a run of data elements between one fixed I/O port and a block of memory. It works one element at a time, in the way a repeated string input or string output operation does. A single start pulse latches the whole job: the transfer direction, the element size, the pointer direction flag, the port address, the starting memory pointer, the repeat enable and the repeat count. The block then issues request/acknowledge accesses on a port bus and on a memory bus, and it never has both requests up at once.

Each element takes two phases. For an input (port to memory), the port is read first and the captured value is then written to memory. For an output (memory to port), memory is read first and the value is then written to the port. After the second phase of each element, the memory pointer moves by the element size, upward or downward as the direction flag says. In repeat mode the count also drops by one. When the block is finished, a one-cycle done pulse is raised. The final pointer and count stay on the outputs until the next start.

Top module: `strio_seq`

## Requirements
- R1: After synchronous reset the block is idle: `busy`, `done`, `port_req` and `mem_req` are all low, and `ptr_out` and `count_out` read zero.
- R2: With `dir_in`=1 (input), each element is a port read (`port_we`=0) at the latched port address. A memory write (`mem_we`=1) at the current pointer follows it and carries the captured port data.
- R3: With `dir_in`=0 (output), each element is a memory read (`mem_we`=0) at the current pointer. A port write (`port_we`=1) follows it and carries the captured memory data.
- R4: The pointer moves by the element size after each element. The `esize` encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is treated as 4 bytes.
- R5: With `down_flag`=0 the pointer increases after each element, and with `down_flag`=1 it decreases. Both directions wrap modulo 2^AW.
- R6: The port address used for every port access is the value latched at start. It stays constant for the whole block.
- R7: With `rep_en`=1 and a nonzero count N, exactly N elements are transferred, `count_out` drops by one per element, and it ends at zero.
- R8: With `rep_en`=1 and a count of zero, `done` is high in the cycle after the start cycle and neither bus is requested.
- R9: With `rep_en`=0, exactly one element is transferred whatever the count, and `count_out` keeps the count latched at start.
- R10: A phase holds its request and address until its acknowledge arrives, so the block works with any acknowledge latency.
- R11: `done` is a single-cycle pulse. `ptr_out` and `count_out` hold their final values after `done` until the next start.
- R12: A start while `busy` is high is ignored. Input changes after the start cycle do not affect the running block.
- R13: Transferred data is masked to the element size: byte lanes above the element size are zero in the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block (accepted only when idle) |
| dir_in | input | 1 | 1 = port to memory, 0 = memory to port |
| esize | input | 2 | Element size code |
| down_flag | input | 1 | 1 = pointer decreases, 0 = increases |
| rep_en | input | 1 | Repeat enable |
| port_addr_in | input | PW | Port address for the block |
| ptr_in | input | AW | Starting memory pointer |
| count_in | input | CW | Repeat count |
| port_req | output | 1 | Port access request |
| port_we | output | 1 | Port access is a write |
| port_addr | output | PW | Port address |
| port_wdata | output | DW | Port write data |
| port_ack | input | 1 | Port access acknowledge |
| port_rdata | input | DW | Port read data, valid with acknowledge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_size | output | 2 | Element size code of the access |
| mem_addr | output | AW | Memory address (current pointer) |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory access acknowledge |
| mem_rdata | input | DW | Memory read data, valid with acknowledge |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle completion pulse |
| ptr_out | output | AW | Current or final pointer |
| count_out | output | CW | Current or final count |

## Verification
The bench sweeps both transfer directions, all four size codes, both pointer directions, repeat on and off, and counts of zero, one and three. It uses start pointers placed so that downward and upward runs wrap through zero, with varying acknowledge latencies. These settings target specific faults:
- A step of the wrong size, or a sign error, gives wrong memory addresses and a wrong final pointer.
- A missing mask leaks upper bytes into the write data.
- Reversed phases show up as a wrong order of events.
- A zero count that is not caught at start produces bus traffic or a late done.
- A non-repeat block that loops, or that modifies the count, is caught by the element count and the final count.
- A block that reloads on a second start during the run shows changed port or pointer addresses.

// File: rtl/strio_pkg.sv
package strio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_DONE   = 2'd3
  } strio_state_t;

  // element size code -> bytes; code 3 behaves as 4 bytes
  function automatic logic [31:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 32'd1;
      2'd1:    size_bytes = 32'd2;
      default: size_bytes = 32'd4;
    endcase
  endfunction

endpackage

// File: rtl/strio_step.sv
module strio_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [1:0]    sz,
  input  logic          down,
  output logic [AW-1:0] next
);
  logic [AW-1:0] step;

  assign step = AW'(strio_pkg::size_bytes(sz));
  assign next = down ? (ptr - step) : (ptr + step);
endmodule

// File: rtl/strio_mask.sv
module strio_mask #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  input  logic [1:0]    sz,
  output logic [DW-1:0] dout
);
  localparam int NLANE = DW / 8;

  logic [31:0] nb;
  assign nb = strio_pkg::size_bytes(sz);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign dout[8*i +: 8] = (i < nb) ? din[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/strio_ctrl.sv
module strio_ctrl
  import strio_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         rep_en,
  input  logic         cnt_zero,
  input  logic         in_mode,
  input  logic         rep_q,
  input  logic         cnt_last,
  input  logic         port_ack,
  input  logic         mem_ack,
  output logic         load,
  output logic         cap,
  output logic         adv,
  output logic         busy,
  output logic         done,
  output strio_state_t state_o
);
  strio_state_t state_q, state_d;
  logic first_ack, second_ack;

  assign first_ack  = in_mode ? port_ack : mem_ack;
  assign second_ack = in_mode ? mem_ack  : port_ack;

  assign load = (state_q == ST_IDLE)   && start;
  assign cap  = (state_q == ST_FIRST)  && first_ack;
  assign adv  = (state_q == ST_SECOND) && second_ack;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (load) state_d = (rep_en && cnt_zero) ? ST_DONE : ST_FIRST;
      ST_FIRST:  if (cap)  state_d = ST_SECOND;
      ST_SECOND: if (adv)  state_d = (rep_q && !cnt_last) ? ST_FIRST : ST_DONE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_DONE);
  assign state_o = state_q;

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_zero_skip_r8: assert property (@(posedge clk) disable iff (rst)
    (load && rep_en && cnt_zero) |=> done);

  p_single_elem_r9: assert property (@(posedge clk) disable iff (rst)
    (adv && !rep_q) |=> done);
endmodule

// File: rtl/strio_seq.sv
module strio_seq
  import strio_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_in,
  input  logic [1:0]    esize,
  input  logic          down_flag,
  input  logic          rep_en,
  input  logic [PW-1:0] port_addr_in,
  input  logic [AW-1:0] ptr_in,
  input  logic [CW-1:0] count_in,
  output logic          port_req,
  output logic          port_we,
  output logic [PW-1:0] port_addr,
  output logic [DW-1:0] port_wdata,
  input  logic          port_ack,
  input  logic [DW-1:0] port_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ptr_out,
  output logic [CW-1:0] count_out
);
  // latched job
  logic          in_q, down_q, rep_q;
  logic [1:0]    sz_q;
  logic [PW-1:0] port_q;
  logic [AW-1:0] ptr_q, ptr_next;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hold_q, cap_masked;

  logic load, cap, adv;
  strio_state_t state;

  strio_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rep_en   (rep_en),
    .cnt_zero (count_in == '0),
    .in_mode  (in_q),
    .rep_q    (rep_q),
    .cnt_last (cnt_q == CW'(1)),
    .port_ack (port_ack),
    .mem_ack  (mem_ack),
    .load     (load),
    .cap      (cap),
    .adv      (adv),
    .busy     (busy),
    .done     (done),
    .state_o  (state)
  );

  strio_step #(.AW(AW)) u_step (
    .ptr  (ptr_q),
    .sz   (sz_q),
    .down (down_q),
    .next (ptr_next)
  );

  strio_mask #(.DW(DW)) u_mask (
    .din  (in_q ? port_rdata : mem_rdata),
    .sz   (sz_q),
    .dout (cap_masked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q   <= 1'b0;
      down_q <= 1'b0;
      rep_q  <= 1'b0;
      sz_q   <= 2'd0;
      port_q <= '0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      if (load) begin
        in_q   <= dir_in;
        down_q <= down_flag;
        rep_q  <= rep_en;
        sz_q   <= esize;
        port_q <= port_addr_in;
        ptr_q  <= ptr_in;
        cnt_q  <= count_in;
      end
      if (cap) hold_q <= cap_masked;
      if (adv) begin
        ptr_q <= ptr_next;
        if (rep_q) cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  // phase decode: input = port then memory, output = memory then port
  assign port_req   = (state == ST_FIRST && in_q) || (state == ST_SECOND && !in_q);
  assign mem_req    = (state == ST_FIRST && !in_q) || (state == ST_SECOND && in_q);
  assign port_we    = port_req && !in_q;
  assign mem_we     = mem_req && in_q;
  assign port_addr  = port_q;
  assign port_wdata = hold_q;
  assign mem_addr   = ptr_q;
  assign mem_wdata  = hold_q;
  assign mem_size   = sz_q;
  assign ptr_out    = ptr_q;
  assign count_out  = cnt_q;

  p_one_bus_r10: assert property (@(posedge clk) disable iff (rst)
    !(port_req && mem_req));

  p_port_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (port_req && !port_ack) |=> (port_req && $stable(port_addr)));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_port_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(port_addr));

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(count_out)) |-> (count_out == $past(count_out) - CW'(1)));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(ptr_out)) |->
      ((AW'(ptr_out - $past(ptr_out)) == AW'(1)) || (AW'($past(ptr_out) - ptr_out) == AW'(1)) ||
       (AW'(ptr_out - $past(ptr_out)) == AW'(2)) || (AW'($past(ptr_out) - ptr_out) == AW'(2)) ||
       (AW'(ptr_out - $past(ptr_out)) == AW'(4)) || (AW'($past(ptr_out) - ptr_out) == AW'(4))));
endmodule

// File: tb/strio_seq_tb_top.sv
module strio_seq_tb_top;
  localparam int AW = 16;
  localparam int PW = 16;
  localparam int DW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, start, dir_in, down_flag, rep_en;
  logic [1:0]    esize;
  logic [PW-1:0] port_addr_in;
  logic [AW-1:0] ptr_in;
  logic [CW-1:0] count_in;
  logic          port_req, port_we, port_ack;
  logic [PW-1:0] port_addr;
  logic [DW-1:0] port_wdata, port_rdata;
  logic          mem_req, mem_we, mem_ack;
  logic [1:0]    mem_size;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          busy, done;
  logic [AW-1:0] ptr_out;
  logic [CW-1:0] count_out;

  strio_seq #(.AW(AW), .PW(PW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .dir_in(dir_in), .esize(esize),
    .down_flag(down_flag), .rep_en(rep_en), .port_addr_in(port_addr_in),
    .ptr_in(ptr_in), .count_in(count_in),
    .port_req(port_req), .port_we(port_we), .port_addr(port_addr),
    .port_wdata(port_wdata), .port_ack(port_ack), .port_rdata(port_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ptr_out(ptr_out), .count_out(count_out)
  );

  int vecs = 0;
  int bad  = 0;
  bit finished = 1'b0;

  // responder state and event logs
  int plat = 0, mlat = 0, pcnt = 0, mcnt = 0, pn = 0, mn = 0, evseq = 0;
  logic          p_we[8], m_we[8];
  logic [PW-1:0] p_ad[8];
  logic [AW-1:0] m_ad[8];
  logic [DW-1:0] p_wd[8], m_wd[8];
  int            p_sq[8], m_sq[8];

  function automatic logic [31:0] pdata(int k);
    return (32'h9E3779B9 * (k + 1)) ^ 32'h0F0F1234;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // port responder
  initial begin
    port_ack = 1'b0;
    port_rdata = '0;
    forever begin
      @(negedge clk);
      if (port_ack) port_ack = 1'b0;
      else if (port_req) begin
        if (pcnt >= plat) begin
          if (pn < 8) begin
            p_we[pn] = port_we; p_ad[pn] = port_addr; p_wd[pn] = port_wdata; p_sq[pn] = evseq;
          end
          port_rdata = pdata(pn);
          port_ack = 1'b1;
          pcnt = 0; pn++; evseq++;
        end else pcnt++;
      end
    end
  end

  // memory responder
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (mcnt >= mlat) begin
          if (mn < 8) begin
            m_we[mn] = mem_we; m_ad[mn] = mem_addr; m_wd[mn] = mem_wdata; m_sq[mn] = evseq;
          end
          mem_rdata = {~mem_addr, mem_addr};
          mem_ack = 1'b1;
          mcnt = 0; mn++; evseq++;
        end else mcnt++;
      end
    end
  end

  task automatic run(bit in_m, logic [1:0] sz, bit dn, bit rp, int cnt,
                     logic [AW-1:0] p0, logic [PW-1:0] pa, int pl, int ml);
    int e, stp, waitc;
    logic [AW-1:0] pk, pfin;
    logic [DW-1:0] msk;
    plat = pl; mlat = ml; pn = 0; mn = 0; pcnt = 0; mcnt = 0;
    @(negedge clk);
    dir_in = in_m; esize = sz; down_flag = dn; rep_en = rp;
    count_in = CW'(cnt); ptr_in = p0; port_addr_in = pa; start = 1'b1;
    @(negedge clk);
    // R12: second start with different job while busy must be ignored
    dir_in = ~in_m; esize = ~sz; down_flag = ~dn; rep_en = 1'b1;
    count_in = CW'(5); ptr_in = ~p0; port_addr_in = ~pa;
    waitc = 1;
    while (!done && waitc < 400) begin
      @(negedge clk);
      start = 1'b0;
      waitc++;
    end
    start = 1'b0;
    e   = rp ? cnt : 1;
    stp = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    msk = (sz == 2'd0) ? 32'h000000FF : (sz == 2'd1) ? 32'h0000FFFF : 32'hFFFFFFFF;
    pfin = dn ? (p0 - AW'(e * stp)) : (p0 + AW'(e * stp));
    chk("R7 done reached", 64'(done), 64'd1);
    if (rp && cnt == 0) begin
      chk("R8 zero count done latency", 64'(waitc), 64'd1);
    end
    chk("R7 R9 port element count", 64'(pn), 64'(e));
    chk("R7 R9 memory element count", 64'(mn), 64'(e));
    chk("R4 R5 final pointer", 64'(ptr_out), 64'(pfin));
    chk("R7 R9 final count", 64'(count_out), rp ? 64'd0 : 64'(cnt));
    for (int k = 0; k < e && k < 8; k++) begin
      pk = dn ? (p0 - AW'(k * stp)) : (p0 + AW'(k * stp));
      chk("R6 R12 port address", 64'(p_ad[k]), 64'(pa));
      chk("R4 R5 R10 memory address", 64'(m_ad[k]), 64'(pk));
      if (in_m) begin
        chk("R2 port is read", 64'(p_we[k]), 64'd0);
        chk("R2 memory is write", 64'(m_we[k]), 64'd1);
        chk("R2 order port before memory", 64'(p_sq[k] < m_sq[k]), 64'd1);
        chk("R2 R13 memory write data", 64'(m_wd[k]), 64'(pdata(k) & msk));
      end else begin
        chk("R3 memory is read", 64'(m_we[k]), 64'd0);
        chk("R3 port is write", 64'(p_we[k]), 64'd1);
        chk("R3 order memory before port", 64'(m_sq[k] < p_sq[k]), 64'd1);
        chk("R3 R13 port write data", 64'(p_wd[k]), 64'({~pk, pk} & msk));
      end
    end
    @(negedge clk);
    chk("R11 done is one cycle", 64'(done), 64'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R11 pointer holds", 64'(ptr_out), 64'(pfin));
    chk("R11 count holds", 64'(count_out), rp ? 64'd0 : 64'(cnt));
    chk("R11 idle after done", 64'(busy), 64'd0);
  endtask

  initial begin
    int idx;
    int cnts[3] = '{0, 1, 3};
    rst = 1'b1; start = 1'b0; dir_in = 1'b0; esize = 2'd0; down_flag = 1'b0;
    rep_en = 1'b0; port_addr_in = '0; ptr_in = '0; count_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 port_req after reset", 64'(port_req), 64'd0);
    chk("R1 mem_req after reset", 64'(mem_req), 64'd0);
    chk("R1 ptr_out after reset", 64'(ptr_out), 64'd0);
    chk("R1 count_out after reset", 64'(count_out), 64'd0);
    idx = 0;
    for (int im = 0; im < 2; im++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 2; d++)
          for (int r = 0; r < 2; r++)
            for (int c = 0; c < 3; c++) begin
              run(im[0], s[1:0], d[0], r[0], cnts[c],
                  idx[0] ? 16'hFFFD : 16'h0002, PW'(16'h03F8 + idx),
                  idx % 3, (idx + 1) % 3);
              idx++;
            end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vecs++;
      bad++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule